// File: doc/BRIEF.md
# Chained Descriptor Fetch Sequencer

This block is the control sequencer of one channel of a descriptor-driven DMA engine. Software writes the word address of the first descriptor into a channel register and sets a start bit. The sequencer then walks a chain of descriptors held in memory. Each descriptor is six 32-bit words. The sequencer reads the six words one at a time over a simple level-held read port and places them in live current-item registers. It then grants beats to a separate transfer engine until the item's remaining byte count reaches zero.

When an item finishes, the sequencer emits a one-cycle item pulse. It then follows the next-descriptor word to the following item. A reserved next value ends the chain. At that point a chain-complete pulse accompanies the final item pulse and the channel goes idle. A half-progress pulse marks the point where the remaining count first drops to half of the item length or below. A pause bit holds off both fetches and beats. Clearing the enable bit abandons the chain at once. The current-item registers can be read at any time through the channel register window. Chip-level address decode places each channel's window at 0x100 plus 0x40 times the channel number.

Top module: `lld_seq`

## Requirements
- R1: After reset the channel is idle, mem_req, xfer_req and all three pulses are low, and every register offset reads zero.
- R2: Writing a 1 in bit 0 at offset 0x00 while idle starts a fetch at the address held at offset 0x08. That address is stored with its two low bits cleared. Bit 0 of offset 0x00 reads 1 from the following cycle until the channel is idle again.
- R3: A descriptor is fetched as six reads at base, base+4, …, base+20, one word per cycle in which mem_req and mem_valid are both high. The words are taken in order as config, source, destination, byte length, parameter and next address. mem_addr does not change while a request waits for mem_valid.
- R4: Offsets 0x0C, 0x10, 0x14, 0x18 and 0x1C read the current config, source, destination, remaining byte count and parameter. Bit 1 of offset 0x04 reads the pause state. Any other offset reads zero, and writes to the read-only offsets change nothing.
- R5: While an item is running, unpaused and its remaining count is nonzero, xfer_req is high. Each cycle with xfer_req and xfer_beat lowers the remaining count by xfer_bytes, and the count saturates at zero.
- R6: In the first unpaused cycle of a running item whose remaining count is zero, item_done rises for one cycle on the next cycle. If the next address is not 0xFFFFF800, fetching restarts at that address with its two low bits cleared.
- R7: When the finished item's next address equals 0xFFFFF800, chain_done is raised in the same cycle as item_done, the channel is idle and bit 0 of offset 0x00 reads 0.
- R8: item_half pulses one cycle after the beat that takes the remaining count from above half the item length (length shifted right by one) to at or below it. It fires at most once per item.
- R9: Bit 1 written at offset 0x04 pauses the channel. While paused, mem_req and xfer_req stay low, no item completes, and beats have no effect on the count. Writing 0 resumes from the same point.
- R10: Writing 0 in bit 0 at offset 0x00 returns the channel to idle on the next cycle from any state. A beat or read return in that cycle is ignored, and no completion pulse follows. The current-item registers keep their values.
- R11: A start write while the channel is busy has no effect on the fetch address or progress.
- R12: An item with byte length zero completes without any beat and without an item_half pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Byte offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mem_req | output | 1 | Descriptor word read request, held until mem_valid |
| mem_addr | output | 32 | Descriptor word address |
| mem_valid | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Beat permission for the transfer engine |
| xfer_beat | input | 1 | Transfer engine moved one beat |
| xfer_bytes | input | BEAT_W | Bytes moved by that beat |
| xfer_cfg | output | 32 | Current item config word |
| xfer_src | output | 32 | Current item source address |
| xfer_dst | output | 32 | Current item destination address |
| item_done | output | 1 | One-cycle pulse after each item |
| item_half | output | 1 | One-cycle half-progress pulse |
| chain_done | output | 1 | One-cycle pulse after the last item |

## Verification
The assertions assume that mem_valid is only meaningful while mem_req is high. They also assume that the transfer engine asserts xfer_beat only when it sees xfer_req. The stimulus holds to both: the memory responder answers on a stall pattern, and beats are offered only while the bench model expects permission. The bench also assumes that software does not place a descriptor at the terminator address, so every chain it builds ends through the next-address word alone.

// File: rtl/lld_pkg.sv
package lld_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    localparam logic [ADDR_W-1:0] CHAIN_END = 32'hFFFF_F800;

    // word positions inside one descriptor (fetch order is behaviour)
    localparam int W_CFG = 0;
    localparam int W_SRC = 1;
    localparam int W_DST = 2;
    localparam int W_LEN = 3;
    localparam int W_PAR = 4;
    localparam int W_NXT = 5;

    // channel window offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_HOLD  = 8'h04;
    localparam logic [7:0] OFS_HEAD  = 8'h08;
    localparam logic [7:0] OFS_CFG   = 8'h0C;
    localparam logic [7:0] OFS_SRC   = 8'h10;
    localparam logic [7:0] OFS_DST   = 8'h14;
    localparam logic [7:0] OFS_LEFT  = 8'h18;
    localparam logic [7:0] OFS_PAR   = 8'h1C;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/lld_item.sv
module lld_item
    import lld_pkg::*;
#(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [WORD_W-1:0] load_word,
    input  logic              beat_ok,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic [WORD_W-1:0] cur_cfg,
    output logic [WORD_W-1:0] cur_src,
    output logic [WORD_W-1:0] cur_dst,
    output logic [WORD_W-1:0] cur_par,
    output logic [WORD_W-1:0] cur_nxt,
    output logic [WORD_W-1:0] left_cnt,
    output logic              empty,
    output logic              half_pulse
);

    logic [WORD_W-1:0] word_q [DESC_WORDS];
    logic [WORD_W-1:0] left_q;
    logic [WORD_W-1:0] take;
    logic [WORD_W-1:0] left_nx;
    logic [WORD_W-1:0] mid;

    always_comb begin
        mid     = word_q[W_LEN] >> 1;
        take    = (WORD_W'(beat_bytes) > left_q) ? left_q : WORD_W'(beat_bytes);
        left_nx = left_q - take;
    end

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= '0;
            else if (load_en && load_idx == IDX_W'(g))
                word_q[g] <= load_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q     <= '0;
            half_pulse <= 1'b0;
        end else begin
            half_pulse <= 1'b0;
            if (load_en && load_idx == IDX_W'(W_LEN)) begin
                left_q <= load_word;
            end else if (beat_ok) begin
                left_q <= left_nx;
                if (left_q > mid && left_nx <= mid)
                    half_pulse <= 1'b1;
            end
        end
    end

    assign cur_cfg  = word_q[W_CFG];
    assign cur_src  = word_q[W_SRC];
    assign cur_dst  = word_q[W_DST];
    assign cur_par  = word_q[W_PAR];
    assign cur_nxt  = word_q[W_NXT];
    assign left_cnt = left_q;
    assign empty    = (left_q == '0);

endmodule

// File: rtl/lld_ctrl.sv
module lld_ctrl
    import lld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              paused,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic              mem_valid,
    input  logic              item_empty,
    input  logic [ADDR_W-1:0] next_addr,
    output seq_state_e        state,
    output logic [IDX_W-1:0]  widx,
    output logic              load_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              xfer_req,
    output logic              item_done,
    output logic              chain_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic [ADDR_W-1:0] base_q;
    logic              finish;
    logic              last;

    always_comb begin
        mem_req  = (state == ST_FETCH) && !paused;
        mem_addr = base_q + (ADDR_W'(widx) << 2);
        xfer_req = (state == ST_RUN) && !paused && !item_empty;
        load_en  = mem_req && mem_valid && !abort;
        finish   = (state == ST_RUN) && !paused && item_empty && !abort;
        last     = (next_addr == CHAIN_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            widx       <= '0;
            base_q     <= '0;
            item_done  <= 1'b0;
            chain_done <= 1'b0;
        end else begin
            item_done  <= finish;
            chain_done <= finish && last;
            if (abort) begin
                state <= ST_IDLE;
                widx  <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (start) begin
                            state  <= ST_FETCH;
                            base_q <= head_addr;
                            widx   <= '0;
                        end
                    end
                    ST_FETCH: begin
                        if (load_en) begin
                            if (widx == LAST_IDX) begin
                                state <= ST_RUN;
                                widx  <= '0;
                            end else begin
                                widx <= widx + 1'b1;
                            end
                        end
                    end
                    ST_RUN: begin
                        if (finish) begin
                            if (last) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_FETCH;
                                base_q <= word_align(next_addr);
                                widx   <= '0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/lld_seq.sv
module lld_seq
    import lld_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    input  logic              xfer_beat,
    input  logic [BEAT_W-1:0] xfer_bytes,
    output logic [31:0]       xfer_cfg,
    output logic [31:0]       xfer_src,
    output logic [31:0]       xfer_dst,
    output logic              item_done,
    output logic              item_half,
    output logic              chain_done
);

    logic [7:0]        ofs;
    logic              wr_ctrl, wr_hold, wr_head;
    logic              start, abort, beat_ok;
    logic              paused_q;
    logic [ADDR_W-1:0] head_q;
    seq_state_e        state;
    logic [IDX_W-1:0]  widx;
    logic              load_en;
    logic              empty;
    logic [31:0]       cur_par, cur_nxt, left_cnt;

    assign ofs     = 8'(reg_addr);
    assign wr_ctrl = reg_wr && ofs == OFS_CTRL;
    assign wr_hold = reg_wr && ofs == OFS_HOLD;
    assign wr_head = reg_wr && ofs == OFS_HEAD;
    assign start   = wr_ctrl && reg_wdata[0];
    assign abort   = wr_ctrl && !reg_wdata[0];
    assign beat_ok = xfer_req && xfer_beat && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            paused_q <= 1'b0;
            head_q   <= '0;
        end else begin
            if (wr_hold) paused_q <= reg_wdata[1];
            if (wr_head) head_q   <= word_align(reg_wdata);
        end
    end

    lld_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .abort      (abort),
        .paused     (paused_q),
        .head_addr  (head_q),
        .mem_valid  (mem_valid),
        .item_empty (empty),
        .next_addr  (cur_nxt),
        .state      (state),
        .widx       (widx),
        .load_en    (load_en),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .xfer_req   (xfer_req),
        .item_done  (item_done),
        .chain_done (chain_done)
    );

    lld_item #(.BEAT_W(BEAT_W)) u_item (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_idx   (widx),
        .load_word  (mem_rdata),
        .beat_ok    (beat_ok),
        .beat_bytes (xfer_bytes),
        .cur_cfg    (xfer_cfg),
        .cur_src    (xfer_src),
        .cur_dst    (xfer_dst),
        .cur_par    (cur_par),
        .cur_nxt    (cur_nxt),
        .left_cnt   (left_cnt),
        .empty      (empty),
        .half_pulse (item_half)
    );

    always_comb begin
        unique case (ofs)
            OFS_CTRL: reg_rdata = {31'b0, state != ST_IDLE};
            OFS_HOLD: reg_rdata = {30'b0, paused_q, 1'b0};
            OFS_HEAD: reg_rdata = head_q;
            OFS_CFG:  reg_rdata = xfer_cfg;
            OFS_SRC:  reg_rdata = xfer_src;
            OFS_DST:  reg_rdata = xfer_dst;
            OFS_LEFT: reg_rdata = left_cnt;
            OFS_PAR:  reg_rdata = cur_par;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lld_seq_chk.sv
module lld_seq_chk
    import lld_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        paused_q,
    input logic        abort,
    input seq_state_e  state,
    input logic        mem_req,
    input logic        mem_valid,
    input logic [31:0] mem_addr,
    input logic        xfer_req,
    input logic        item_done,
    input logic        chain_done
);

    // R9
    paused_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        paused_q |-> (!mem_req && !xfer_req));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (!mem_req || $stable(mem_addr)));

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R5
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && xfer_req));

    // R7
    chain_with_item_chk: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> (item_done && state == ST_IDLE));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == ST_IDLE && !item_done && !mem_req && !xfer_req));

endmodule

bind lld_seq lld_seq_chk u_lld_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .paused_q   (paused_q),
    .abort      (abort),
    .state      (state),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .xfer_req   (xfer_req),
    .item_done  (item_done),
    .chain_done (chain_done)
);

// File: tb/lld_seq_bench.sv
module lld_seq_bench;

    localparam logic [31:0] TERM = 32'hFFFF_F800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        xfer_req;
    logic        xfer_beat = 1'b0;
    logic [7:0]  xfer_bytes = '0;
    logic [31:0] xfer_cfg, xfer_src, xfer_dst;
    logic        item_done, item_half, chain_done;

    always #2.5 clk = ~clk;

    lld_seq u_lld_seq (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // memory image
    logic [31:0] mem [256];

    // behavioural reference state
    int          m_state = 0;  // 0 idle, 1 fetching, 2 running
    int          m_widx = 0;
    logic [31:0] m_base = 0, m_head = 0;
    bit          m_paused = 0;
    logic [31:0] m_w [6];
    logic [31:0] m_left = 0;
    bit          m_idone = 0, m_ihalf = 0, m_cdone = 0;

    // stimulus controls
    bit          s_wr = 0;
    logic [5:0]  s_addr = 0;
    logic [31:0] s_data = 0;
    bit          s_beat = 0;
    logic [7:0]  s_bytes = 4;
    int          s_stall = 0;
    int          n_idone = 0, n_cdone = 0, n_half = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual 0x%08h expected 0x%08h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return {31'b0, m_state != 0};
            6'h04: return {30'b0, m_paused, 1'b0};
            6'h08: return m_head;
            6'h0C: return m_w[0];
            6'h10: return m_w[1];
            6'h14: return m_w[2];
            6'h18: return m_left;
            6'h1C: return m_w[4];
            default: return 32'h0;
        endcase
    endfunction

    task automatic tick();
        bit          e_mreq, e_xreq, abort, vld;
        logic [31:0] e_addr, take, nl, mid;
        e_mreq = (m_state == 1) && !m_paused;
        e_addr = m_base + 32'(m_widx * 4);
        e_xreq = (m_state == 2) && !m_paused && (m_left != 0);
        vld    = (s_stall == 0) ? 1'b1 : ((cyc % 3) != 1);
        reg_wr    = s_wr;
        reg_addr  = s_wr ? s_addr : 6'(4 * (cyc % 9));
        reg_wdata = s_data;
        mem_valid = vld;
        mem_rdata = mem[(e_addr >> 2) & 32'hFF];
        xfer_beat = s_beat && e_xreq;
        xfer_bytes = s_bytes;
        #1;
        // R3 fetch port
        chk(mem_req === e_mreq, "R3", 32'(mem_req), 32'(e_mreq));
        if (e_mreq) chk(mem_addr === e_addr, "R3", mem_addr, e_addr);
        // R5 / R9 beat permission
        chk(xfer_req === e_xreq, m_paused ? "R9" : "R5", 32'(xfer_req), 32'(e_xreq));
        chk(xfer_cfg === m_w[0] && xfer_src === m_w[1] && xfer_dst === m_w[2], "R3",
            xfer_src, m_w[1]);
        // R6 / R7 / R8 pulses
        chk(item_done === m_idone, "R6", 32'(item_done), 32'(m_idone));
        chk(chain_done === m_cdone, "R7", 32'(chain_done), 32'(m_cdone));
        chk(item_half === m_ihalf, "R8", 32'(item_half), 32'(m_ihalf));
        // R4 / R1 readback
        chk(reg_rdata === m_read(reg_addr), (cyc < 12) ? "R1" : "R4", reg_rdata, m_read(reg_addr));
        n_idone += int'(m_idone); n_cdone += int'(m_cdone); n_half += int'(m_ihalf);
        // reference next state
        abort = s_wr && s_addr == 6'h00 && !s_data[0];
        m_idone = 0; m_cdone = 0; m_ihalf = 0;
        if (abort) begin
            m_state = 0; m_widx = 0;
        end else if (m_state == 0) begin
            if (s_wr && s_addr == 6'h00 && s_data[0]) begin
                m_state = 1; m_base = m_head; m_widx = 0;
            end
        end else if (m_state == 1) begin
            if (e_mreq && vld) begin
                m_w[m_widx] = mem_rdata;
                if (m_widx == 3) m_left = mem_rdata;
                if (m_widx == 5) begin m_state = 2; m_widx = 0; end
                else m_widx++;
            end
        end else begin
            if (e_xreq && xfer_beat) begin
                take = (32'(s_bytes) > m_left) ? m_left : 32'(s_bytes);
                nl = m_left - take;
                mid = m_w[3] >> 1;
                if (m_left > mid && nl <= mid) m_ihalf = 1;
                m_left = nl;
            end else if (!m_paused && m_left == 0) begin
                m_idone = 1;
                if (m_w[5] == TERM) begin m_cdone = 1; m_state = 0; end
                else begin m_state = 1; m_base = {m_w[5][31:2], 2'b00}; m_widx = 0; end
            end
        end
        if (s_wr && s_addr == 6'h04) m_paused = s_data[1];
        if (s_wr && s_addr == 6'h08) m_head = {s_data[31:2], 2'b00};
        @(posedge clk);
        @(negedge clk);
        cyc++;
        s_wr = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        s_wr = 1; s_addr = a; s_data = d;
        tick();
    endtask

    task automatic put_desc(input int wa, input logic [31:0] c, s, d, l, p, n);
        mem[wa] = c; mem[wa+1] = s; mem[wa+2] = d; mem[wa+3] = l; mem[wa+4] = p; mem[wa+5] = n;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        for (int i = 0; i < 6; i++) m_w[i] = 0;
        // chain: 0x100 (len 16) -> 0x143 (len 0) -> 0x180 (len 5) -> end
        put_desc(32'h40, 32'h0001_0011, 32'h0000_A000, 32'h0000_B000, 32'd16, 32'd8, 32'h143);
        put_desc(32'h50, 32'h0002_0022, 32'h0000_A100, 32'h0000_B100, 32'd0,  32'd9, 32'h180);
        put_desc(32'h60, 32'h0003_0033, 32'h0000_A200, 32'h0000_B200, 32'd5,  32'd7, TERM);
        // descriptor used for abort tests
        put_desc(32'h80, 32'h0004_0044, 32'h0000_C000, 32'h0000_D000, 32'd40, 32'd1, TERM);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(10);                              // R1 reset state, all offsets
        wr(6'h0C, 32'h1234_5678);             // R4 read-only write ignored
        wr(6'h18, 32'h0000_00FF);             // R4
        run(9);
        wr(6'h08, 32'h0000_0102);             // R2 head aligned to 0x100
        s_stall = 1;
        wr(6'h00, 32'h1);                     // R2 start
        run(4);
        wr(6'h08, 32'h0000_0200);             // head change mid-chain
        wr(6'h00, 32'h1);                     // R11 start while busy ignored
        run(6);
        s_beat = 1; s_bytes = 4;
        run(2);
        wr(6'h04, 32'h2);                     // R9 pause
        run(5);
        wr(6'h04, 32'h0);                     // R9 resume
        run(4);                               // R8 half at 8, R6 next item
        run(16);                              // R12 zero-length item
        s_bytes = 3;                          // R5 saturate: 5 -> 2 -> 0
        run(30);                              // R7 chain end
        chk(n_idone == 3, "R6", 32'(n_idone), 32'd3);
        chk(n_cdone == 1, "R7", 32'(n_cdone), 32'd1);
        chk(n_half == 2, "R8", 32'(n_half), 32'd2);
        // R10 abort during fetch
        wr(6'h08, 32'h0000_0200);
        wr(6'h00, 32'h1);
        run(3);
        wr(6'h00, 32'h0);
        run(9);
        // R10 abort during run with a beat in the same cycle
        s_stall = 0; s_bytes = 4;
        wr(6'h00, 32'h1);
        run(9);
        wr(6'h00, 32'h0);
        run(12);
        chk(n_cdone == 1, "R10", 32'(n_cdone), 32'd1);
        // R9 pause before start: nothing fetched until resume
        wr(6'h04, 32'h2);
        wr(6'h00, 32'h1);
        run(6);
        wr(6'h04, 32'h0);
        run(30);
        chk(n_cdone == 2, "R7", 32'(n_cdone), 32'd2);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule